// File: doc/BRIEF.md
# Sectored Flash Register Interface

This block places a register-mapped control path between a processor data bus and a behavioural model of a non-volatile word array. The array holds 4096 words of 24 bits, split into three sectors of unequal size. Software sets an address and a 24-bit operand, which is split across a low and a high 16-bit data register. It then writes a command code to the control register. The block sequences the command, holds a busy flag while the command runs, and reports a mismatch flag and a sticky error flag.

Three commands act on the main array: a sector erase that sets every word of a sector to all ones, a program that can only clear bits, and a verify that compares a stored word with the operand. A separate bank of four 8-bit non-volatile registers sits beside the array. These registers erase to zero and can be programmed and read through their own window. The array is modelled in registers. Cell physics and pump timing are not modelled.

Top module: `flash_regif`

## Requirements
- R1: After reset, the control, address, data-low and data-high registers all read as zero.
- R2: The register select codes are 0 control, 1 address, 2 data-low, 3 data-high and 4 special-register window. Data-low carries word bits 15:0. Bits 7:0 of data-high carry word bits 23:16, and bits 15:8 of data-high always read as zero.
- R3: An erase acts on the one sector that contains the address register, and only on that sector. Sector 0 is words 0..255, sector 1 is words 256..511, and sector 2 is words 512..4095.
- R4: An erase sets every word of its sector to 0xFFFFFF. Busy stays high for exactly as many cycles as the sector has words.
- R5: Program, verify, special program and special erase each hold busy (control bit 0) high for exactly OP_CYCLES cycles after the clock edge that accepts the command.
- R6: A program replaces the addressed word with the old word AND the 24-bit operand.
- R7: A verify clears the mismatch flag (control bit 2) when it starts. When it ends, the flag is set if the stored word differs from the operand and left clear otherwise.
- R8: A valid command written while busy is ignored and leaves the array unchanged. It also sets the error flag (control bit 1), which stays set until reset.
- R9: The address and operand are captured when a command is accepted. Writes to those registers while busy do not change the result.
- R10: A special erase sets all four special registers to zero. A special program ORs data-low bits 7:0 into the special register selected by address bits 1:0. Window 4 returns the selected register in bits 7:0. Neither special operation alters the main array.
- R11: The command code is control write bits 2:0: 1 erase, 2 program, 3 verify, 4 special program, 5 special erase. Codes 0, 6 and 7 start nothing, do not raise busy and never set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register, combinational |

## Verification
The assertions assume that reg_sel and wdata are stable whenever wr_en is sampled. They also assume that a program or verify is only judged against an address that an erase has already defined. The stimulus always erases a sector before it programs or verifies words in it, and it erases the special bank before it programs any special register. All bus writes are driven at the falling clock edge, so each write is seen by exactly one rising edge.

// File: rtl/flash_pkg.sv
package flash_pkg;
   localparam logic [2:0] CMD_NONE   = 3'd0;
   localparam logic [2:0] CMD_ERASE  = 3'd1;
   localparam logic [2:0] CMD_PROG   = 3'd2;
   localparam logic [2:0] CMD_VERIFY = 3'd3;
   localparam logic [2:0] CMD_SPROG  = 3'd4;
   localparam logic [2:0] CMD_SERASE = 3'd5;

   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_ADDR = 3'd1;
   localparam logic [2:0] SEL_DLO  = 3'd2;
   localparam logic [2:0] SEL_DHI  = 3'd3;
   localparam logic [2:0] SEL_SPEC = 3'd4;

   typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_OP} seq_st_e;

   function automatic logic cmd_valid(input logic [2:0] c);
      return (c >= CMD_ERASE) && (c <= CMD_SERASE);
   endfunction
endpackage

// File: rtl/flash_sector_dec.sv
module flash_sector_dec #(
   parameter int WORDS    = 4096,
   parameter int S0_WORDS = 256,
   parameter int S1_WORDS = 256,
   localparam int AW      = $clog2(WORDS)
) (
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] base,
   output logic [AW-1:0] last
);
   localparam logic [AW-1:0] B1 = AW'(S0_WORDS);
   localparam logic [AW-1:0] B2 = AW'(S0_WORDS + S1_WORDS);

   always_comb begin
      if (addr < B1) begin
         base = '0;
         last = B1 - AW'(1);
      end else if (addr < B2) begin
         base = B1;
         last = B2 - AW'(1);
      end else begin
         base = B2;
         last = AW'(WORDS - 1);
      end
   end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_pkg::*;
#(
   parameter int AW         = 12,
   parameter int OP_CYCLES  = 4,
   localparam int CW        = $clog2(OP_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_erase,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] last,
   output logic          busy,
   output logic          op_done,
   output logic          erase_we,
   output logic [AW-1:0] erase_ptr
);
   seq_st_e       st;
   logic [CW-1:0] cnt;
   logic [AW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         erase_ptr <= '0;
         last_q    <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               if (start_erase) begin
                  st        <= ST_ERASE;
                  erase_ptr <= base;
                  last_q    <= last;
               end else begin
                  st  <= ST_OP;
                  cnt <= CW'(OP_CYCLES - 1);
               end
            end
            ST_ERASE: begin
               erase_ptr <= erase_ptr + AW'(1);
               if (erase_ptr == last_q) st <= ST_IDLE;
            end
            ST_OP: begin
               if (cnt == '0) st <= ST_IDLE;
               else           cnt <= cnt - CW'(1);
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign erase_we = (st == ST_ERASE);
   assign op_done  = (st == ST_OP) && (cnt == '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int WORDS = 4096,
   parameter int DW    = 24,
   parameter int NSPEC = 4,
   parameter int SW    = 8,
   localparam int AW   = $clog2(WORDS),
   localparam int SPW  = $clog2(NSPEC)
) (
   input  logic           clk,
   input  logic           we,
   input  logic [AW-1:0]  waddr,
   input  logic [DW-1:0]  wdata,
   input  logic [AW-1:0]  raddr,
   output logic [DW-1:0]  rd,
   input  logic           spec_prog,
   input  logic           spec_erase,
   input  logic [SPW-1:0] spec_wsel,
   input  logic [SW-1:0]  spec_wdata,
   input  logic [SPW-1:0] spec_rsel,
   output logic [SW-1:0]  spec_rd
);
   logic [DW-1:0] mem [WORDS];
   logic [SW-1:0] spec [NSPEC];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end
   assign rd = mem[raddr];

   for (genvar i = 0; i < NSPEC; i++) begin : g_spec
      always_ff @(posedge clk) begin
         if (spec_erase)
            spec[i] <= '0;
         else if (spec_prog && (spec_wsel == SPW'(i)))
            spec[i] <= spec[i] | spec_wdata;
      end
   end
   assign spec_rd = spec[spec_rsel];
endmodule

// File: rtl/flash_regif.sv
module flash_regif
   import flash_pkg::*;
#(
   parameter int WORDS     = 4096,
   parameter int DW        = 24,
   parameter int S0_WORDS  = 256,
   parameter int S1_WORDS  = 256,
   parameter int NSPEC     = 4,
   parameter int OP_CYCLES = 4,
   localparam int AW       = $clog2(WORDS),
   localparam int HW       = DW - 16,
   localparam int SPW      = $clog2(NSPEC)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [2:0]  reg_sel,
   input  logic [15:0] wdata,
   output logic [15:0] rdata
);
   if (DW <= 16 || DW > 32) begin : g_bad_dw
      $error("flash_regif: DW must lie in 17..32");
   end
   if (AW > 16 || (1 << AW) != WORDS) begin : g_bad_words
      $error("flash_regif: WORDS must be a power of two up to 65536");
   end
   if (S0_WORDS < 1 || S1_WORDS < 1 || S0_WORDS + S1_WORDS >= WORDS) begin : g_bad_sec
      $error("flash_regif: sector sizes leave no room for sector 2");
   end
   if (OP_CYCLES < 1 || NSPEC < 2 || NSPEC > (1 << AW)) begin : g_bad_misc
      $error("flash_regif: OP_CYCLES or NSPEC out of range");
   end

   logic [AW-1:0] addr_q, op_addr_q;
   logic [15:0]   dlo_q;
   logic [HW-1:0] dhi_q;
   logic [DW-1:0] op_data_q;
   logic [2:0]    op_cmd_q;
   logic          err_q, mis_q;

   logic          busy, op_done, erase_we, ctrl_wr, accept;
   logic [AW-1:0] erase_ptr, sec_base, sec_last;
   logic [DW-1:0] arr_rd;
   logic [7:0]    spec_rd;

   assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL) && cmd_valid(wdata[2:0]);
   assign accept  = ctrl_wr && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         dlo_q     <= '0;
         dhi_q     <= '0;
         op_addr_q <= '0;
         op_data_q <= '0;
         op_cmd_q  <= CMD_NONE;
         err_q     <= 1'b0;
         mis_q     <= 1'b0;
      end else begin
         if (wr_en && reg_sel == SEL_ADDR) addr_q <= wdata[AW-1:0];
         if (wr_en && reg_sel == SEL_DLO)  dlo_q  <= wdata;
         if (wr_en && reg_sel == SEL_DHI)  dhi_q  <= wdata[HW-1:0];
         if (ctrl_wr && busy) err_q <= 1'b1;
         if (accept) begin
            op_cmd_q  <= wdata[2:0];
            op_addr_q <= addr_q;
            op_data_q <= {dhi_q, dlo_q};
            if (wdata[2:0] == CMD_VERIFY) mis_q <= 1'b0;
         end
         if (op_done && op_cmd_q == CMD_VERIFY) mis_q <= (arr_rd != op_data_q);
      end
   end

   flash_sector_dec #(.WORDS(WORDS), .S0_WORDS(S0_WORDS), .S1_WORDS(S1_WORDS)) u_dec (
      .addr (addr_q),
      .base (sec_base),
      .last (sec_last)
   );

   flash_seq #(.AW(AW), .OP_CYCLES(OP_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept),
      .start_erase (wdata[2:0] == CMD_ERASE),
      .base        (sec_base),
      .last        (sec_last),
      .busy        (busy),
      .op_done     (op_done),
      .erase_we    (erase_we),
      .erase_ptr   (erase_ptr)
   );

   flash_array #(.WORDS(WORDS), .DW(DW), .NSPEC(NSPEC), .SW(8)) u_arr (
      .clk        (clk),
      .we         (erase_we || (op_done && op_cmd_q == CMD_PROG)),
      .waddr      (erase_we ? erase_ptr : op_addr_q),
      .wdata      (erase_we ? {DW{1'b1}} : (arr_rd & op_data_q)),
      .raddr      (op_addr_q),
      .rd         (arr_rd),
      .spec_prog  (op_done && op_cmd_q == CMD_SPROG),
      .spec_erase (op_done && op_cmd_q == CMD_SERASE),
      .spec_wsel  (op_addr_q[SPW-1:0]),
      .spec_wdata (op_data_q[7:0]),
      .spec_rsel  (addr_q[SPW-1:0]),
      .spec_rd    (spec_rd)
   );

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL: rdata = {13'b0, mis_q, err_q, busy};
         SEL_ADDR: rdata = 16'(addr_q);
         SEL_DLO:  rdata = dlo_q;
         SEL_DHI:  rdata = 16'(dhi_q);
         SEL_SPEC: rdata = {8'b0, spec_rd};
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/flash_regif_chk.sv
module flash_regif_chk #(
   parameter int OP_CYCLES = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [2:0]  reg_sel,
   input logic [15:0] wdata,
   input logic [15:0] rdata,
   input logic        busy,
   input logic        err_q
);
   logic        cmd_wr, idle_wr;
   logic [15:0] run_len;
   logic        run_erase;

   assign cmd_wr  = wr_en && reg_sel == 3'd0 && wdata[2:0] >= 3'd1 && wdata[2:0] <= 3'd5;
   assign idle_wr = wr_en && reg_sel == 3'd0 && (wdata[2:0] == 3'd0 || wdata[2:0] >= 3'd6);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len   <= '0;
         run_erase <= 1'b0;
      end else if (cmd_wr && !busy) begin
         run_len   <= '0;
         run_erase <= (wdata[2:0] == 3'd1);
      end else if (busy) begin
         run_len   <= run_len + 16'd1;
      end
   end

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr) |=> err_q);
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr) |=> busy);
   p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && idle_wr) |=> !busy);
   p_op_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !run_erase) |-> run_len == 16'(OP_CYCLES));
   p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 3'd3) |-> rdata[15:8] == 8'd0);
endmodule

bind flash_regif flash_regif_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .reg_sel (reg_sel),
   .wdata   (wdata),
   .rdata   (rdata),
   .busy    (busy),
   .err_q   (err_q)
);

// File: tb/tb_flash_regif.sv
module tb_flash_regif;
   localparam int OPC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;

   int total = 0;
   int bad = 0;
   logic        mon_req = 1'b0;
   logic [15:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   flash_regif #(.OP_CYCLES(OPC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata)
   );

   task automatic judge(input int act, input int exp, input string tag);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected item when a read is presented
   always @(posedge mon_req) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      judge(int'(rdata), int'(e), t);
   end

   // driver: present a read and push its expected value
   task automatic expect_rd(input logic [2:0] sel, input logic [15:0] e, input string tag);
      @(negedge clk);
      reg_sel = sel;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #2 mon_req = 1'b1;
      #1 mon_req = 1'b0;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      reg_sel = 3'd0;
      #1;
      while (rdata[0]) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic set_word(input int a, input logic [23:0] d);
      wr(3'd1, 16'(a));
      wr(3'd2, d[15:0]);
      wr(3'd3, {8'h00, d[23:16]});
   endtask

   task automatic run(input logic [2:0] c, input int exp_len, input string tag);
      int n;
      wr(3'd0, {13'd0, c});
      wait_idle(n);
      if (exp_len > 0) judge(n, exp_len, tag);
   endtask

   task automatic verify(input int a, input logic [23:0] d, input logic [15:0] ctrl, input string tag);
      set_word(a, d);
      run(3'd3, OPC, "R5 verify length");
      expect_rd(3'd0, ctrl, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_rd(3'd0, 16'h0000, "R1 ctrl after reset");
      expect_rd(3'd1, 16'h0000, "R1 addr after reset");
      expect_rd(3'd2, 16'h0000, "R1 dlo after reset");
      expect_rd(3'd3, 16'h0000, "R1 dhi after reset");
      // R2 layout
      wr(3'd3, 16'hABCD);
      expect_rd(3'd3, 16'h00CD, "R2 dhi upper byte zero");
      wr(3'd2, 16'h1234);
      expect_rd(3'd2, 16'h1234, "R2 dlo readback");
      // R11 undefined code starts nothing
      wr(3'd0, 16'h0006);
      expect_rd(3'd0, 16'h0000, "R11 code 6 no busy no error");
      wr(3'd0, 16'h0000);
      expect_rd(3'd0, 16'h0000, "R11 code 0 no busy");
      // R10 special bank
      run(3'd5, OPC, "R5 special erase length");
      for (int i = 0; i < 4; i++) begin
         wr(3'd1, 16'(i));
         expect_rd(3'd4, 16'h0000, "R10 special erased to zero");
      end
      wr(3'd1, 16'd2); wr(3'd2, 16'h005A);
      run(3'd4, OPC, "R5 special program length");
      expect_rd(3'd4, 16'h005A, "R10 special program");
      wr(3'd1, 16'd1);
      expect_rd(3'd4, 16'h0000, "R10 other special untouched");
      wr(3'd1, 16'd2); wr(3'd2, 16'h0081);
      run(3'd4, OPC, "R5 special program length");
      expect_rd(3'd4, 16'h00DB, "R10 special program ORs bits");
      // R3/R4 sectors
      wr(3'd1, 16'd10);
      run(3'd1, 256, "R4 erase sector 0 length");
      set_word(255, 24'h000000);
      run(3'd2, OPC, "R5 program length");
      wr(3'd1, 16'd300);
      run(3'd1, 256, "R3 erase sector 1 length");
      verify(255, 24'h000000, 16'h0000, "R3 word 255 kept by sector 1 erase");
      verify(256, 24'hFFFFFF, 16'h0000, "R4 word 256 erased");
      verify(0, 24'hFFFFFF, 16'h0000, "R4 word 0 erased");
      set_word(511, 24'h000000);
      run(3'd2, OPC, "R5 program length");
      wr(3'd1, 16'd4000);
      run(3'd1, 3584, "R3 erase sector 2 length");
      verify(511, 24'h000000, 16'h0000, "R3 word 511 kept by sector 2 erase");
      verify(512, 24'hFFFFFF, 16'h0000, "R4 word 512 erased");
      verify(4095, 24'hFFFFFF, 16'h0000, "R4 word 4095 erased");
      // R6/R7 program AND and mismatch
      set_word(300, 24'h123456);
      run(3'd2, OPC, "R5 program length");
      verify(300, 24'h123456, 16'h0000, "R6 program from erased");
      set_word(300, 24'hFFFF00);
      run(3'd2, OPC, "R5 program length");
      verify(300, 24'h123456, 16'h0004, "R7 mismatch set");
      verify(300, 24'h123400, 16'h0000, "R6 program ANDs old word");
      // R9 operands captured at accept
      set_word(600, 24'h0F0F0F);
      wr(3'd0, 16'h0002);
      wr(3'd1, 16'd601); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
      wait_idle(n);
      verify(600, 24'h0F0F0F, 16'h0000, "R9 program used captured operand");
      verify(601, 24'hFFFFFF, 16'h0000, "R9 other address untouched");
      // R8 command while busy
      set_word(700, 24'h00AA55);
      wr(3'd0, 16'h0002);
      wr(3'd0, 16'h0001);
      expect_rd(3'd0, 16'h0003, "R8 error set while busy");
      wait_idle(n);
      verify(700, 24'h00AA55, 16'h0002, "R8 rejected erase did not run");
      // R10 special ops leave array alone; R8 error sticky
      run(3'd5, OPC, "R5 special erase length");
      verify(700, 24'h00AA55, 16'h0002, "R10 array kept after special erase");
      wr(3'd1, 16'd2);
      expect_rd(3'd4, 16'h0000, "R10 special erase clears");
      expect_rd(3'd0, 16'h0002, "R8 error sticky");
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule